// File: doc/BRIEF.md
# Receive Cell Screening Filter

This block sits between a cell receiver and four receive FIFO ports. It takes a byte-wide stream of fixed-length cells and decides, one cell at a time, whether the cell goes out and to which port. Each cell carries a port number and a start-of-cell flag on its first byte. The CRC and length verdicts for the cell arrive with its last byte. Because those verdicts come last, every cell is first held in a buffer. The decision is made once the cell is complete, and the cell is then replayed to its port as a whole or not at all.

The screening has several parts. Each port has three control bits: reception off, CRC check ignored and length check ignored. Cells whose header matches a programmable idle pattern under a mask can be dropped. Write strobes for invalid cells can be suppressed. Odd parity is checked on every input byte. The CRC error counter and the length error counter are shared by all ports. They count every failing cell, whatever the per-port ignore bits say.

All configuration inputs are sampled on the first byte of a cell and held for the rest of that cell. A setting changed in the middle of a cell therefore takes effect with the next cell.

Top module: `cell_screen_filter`

## Requirements
- R1: A forwarded cell produces exactly 53 write strobes on `out_wr` bit `in_port` and on no other bit. Each strobe carries the cell's bytes in input order on `out_byte`. Byte 0 appears on the third rising edge after the last input byte is accepted.
- R2: A cell addressed to port p with `port_rx_off[p]`=1 produces no write strobes. A cell addressed to a port with the bit at 0 is forwarded, provided no other screening rule drops it.
- R3: `port_rx_off` is sampled on byte 0 of a cell. Toggling it during the cell changes neither the number of strobes nor the data of that cell, which is passed or dropped in full.
- R4: A cell is invalid when its CRC failed (`in_crc_ok`=0 on byte 52) and `port_crc_ign[p]`=0. When `port_crc_ign[p]`=1, a CRC failure does not make the cell invalid.
- R5: A cell is invalid when its length failed (`in_len_ok`=0 on byte 52) and `port_len_ign[p]`=0. When `port_len_ign[p]`=1, a length failure does not make the cell invalid.
- R6: Every cell with a CRC failure gives one `crc_err_pulse` and adds one to `crc_err_cnt`. Every cell with a length failure does the same on `len_err_pulse` and `len_err_cnt`. This holds whatever the port, the ignore bits or the forwarding decision.
- R7: The header is bytes 0 to 3, with byte 0 in bits 31:24. It is idle when `((header ^ idle_pattern) & idle_mask) == 0`, so mask bit 1 means compare. An idle cell is dropped when `idle_drop_en`=1 and forwarded when `idle_drop_en`=0.
- R8: When `invalid_strobe_inh`=1, an invalid cell produces no strobes. When it is 0, an invalid cell is forwarded in full.
- R9: With `par_chk_en`=1, a byte with even parity over {`in_byte`,`in_par`} does three things. It gives one `par_err_pulse` on the next edge, sets the sticky `par_err_flag`, and makes its cell invalid.
- R10: With `par_chk_en`=0, `par_err_pulse` and `par_err_flag` stay low, and parity errors do not make a cell invalid.
- R11: After reset, `out_wr`, the error pulses, `par_err_flag` and both counters are zero.
- R12: At most one bit of `out_wr` is high in any cycle, and the active bit does not change within a cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte valid |
| in_soc | input | 1 | Marks byte 0 of a cell |
| in_byte | input | 8 | Cell byte |
| in_par | input | 1 | Odd parity bit for in_byte |
| in_port | input | 2 | Destination port, sampled on byte 0 |
| in_crc_ok | input | 1 | Payload CRC verdict, sampled on byte 52 |
| in_len_ok | input | 1 | Payload length verdict, sampled on byte 52 |
| port_rx_off | input | 4 | Per-port reception disable |
| port_crc_ign | input | 4 | Per-port CRC check ignore |
| port_len_ign | input | 4 | Per-port length check ignore |
| idle_drop_en | input | 1 | Drop cells whose header matches the idle pattern |
| idle_pattern | input | 32 | Idle header value |
| idle_mask | input | 32 | Idle compare mask (1 = compare) |
| invalid_strobe_inh | input | 1 | Suppress strobes of invalid cells |
| par_chk_en | input | 1 | Enable input parity checking |
| out_byte | output | 8 | Shared output byte |
| out_wr | output | 4 | Per-port write strobe |
| crc_err_pulse | output | 1 | One pulse per CRC-failed cell |
| len_err_pulse | output | 1 | One pulse per length-failed cell |
| par_err_pulse | output | 1 | One pulse per parity-failed byte |
| par_err_flag | output | 1 | Sticky parity error status |
| crc_err_cnt | output | 16 | Shared CRC error count |
| len_err_cnt | output | 16 | Shared length error count |

## Verification
The assertions assume the input obeys the cell framing:
- `in_soc` is high exactly on the byte where the internal byte index is zero.
- Cells are never closer together than one cell time, so a new replay starts only when the previous one is in its last cycle or finished.

The bench always sends whole 53-byte cells with the flag on byte 0 only, and keeps at least one idle cycle between cells. Configuration changes are made only between cells, except in the one test that toggles reception disable mid-cell on purpose. Under that stimulus, the counter-step, strobe one-hot and parity-gating properties hold.

// File: rtl/cell_screen_pkg.sv
package cell_screen_pkg;
  localparam int PORTS      = 4;
  localparam int PORT_W     = $clog2(PORTS);
  localparam int CELL_BYTES = 53;
  localparam int HDR_BYTES  = 4;
  localparam int HDR_W      = 8 * HDR_BYTES;
  localparam int IDX_W      = $clog2(CELL_BYTES);
  localparam int BUF_DEPTH  = 2 * CELL_BYTES;
  localparam int ADDR_W     = $clog2(BUF_DEPTH);

  // Everything the verdict stage needs about one finished cell
  typedef struct packed {
    logic [PORT_W-1:0] port;
    logic              bank;
    logic              rx_off;
    logic              idle_hit;
    logic              crc_bad;
    logic              crc_ign;
    logic              len_bad;
    logic              len_ign;
    logic              par_bad;
    logic              strobe_inh;
  } cell_desc_t;

  function automatic logic odd_ok(input logic [7:0] b, input logic p);
    return ^{b, p};
  endfunction
endpackage

// File: rtl/cell_buffer.sv
module cell_buffer #(
  parameter int DW    = 8,
  parameter int DEPTH = 106,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/cell_capture.sv
module cell_capture
  import cell_screen_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_soc,
  input  logic [7:0]        in_byte,
  input  logic              in_par,
  input  logic [PORT_W-1:0] in_port,
  input  logic              in_crc_ok,
  input  logic              in_len_ok,
  input  logic [PORTS-1:0]  port_rx_off,
  input  logic [PORTS-1:0]  port_crc_ign,
  input  logic [PORTS-1:0]  port_len_ign,
  input  logic              idle_drop_en,
  input  logic [HDR_W-1:0]  idle_pattern,
  input  logic [HDR_W-1:0]  idle_mask,
  input  logic              invalid_strobe_inh,
  input  logic              par_chk_en,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              done,
  output cell_desc_t        desc,
  output logic              par_err_pulse,
  output logic              par_err_flag
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELL_BYTES - 1);
  localparam logic [IDX_W-1:0] HDR_END  = IDX_W'(HDR_BYTES);

  logic [IDX_W-1:0]  idx_q;
  logic              bank_q;
  logic              first_b, last_b;

  // configuration snapshot taken on byte 0
  logic [PORT_W-1:0] s_port;
  logic              s_rx_off, s_crc_ign, s_len_ign, s_idle_en, s_inh, s_par_en;
  logic [HDR_W-1:0]  s_pat, s_mask;

  logic [PORT_W-1:0] c_port;
  logic              c_rx_off, c_crc_ign, c_len_ign, c_idle_en, c_inh, c_par_en;
  logic [HDR_W-1:0]  c_pat, c_mask;

  logic [HDR_W-1:0]  hdr_q;
  logic              pbad_q, byte_bad, cell_pbad, idle_hit;

  assign first_b = in_valid && (idx_q == '0);
  assign last_b  = in_valid && (idx_q == LAST_IDX);

  always_comb begin
    if (first_b) begin
      c_port    = in_port;
      c_rx_off  = port_rx_off[in_port];
      c_crc_ign = port_crc_ign[in_port];
      c_len_ign = port_len_ign[in_port];
      c_idle_en = idle_drop_en;
      c_pat     = idle_pattern;
      c_mask    = idle_mask;
      c_inh     = invalid_strobe_inh;
      c_par_en  = par_chk_en;
    end else begin
      c_port    = s_port;
      c_rx_off  = s_rx_off;
      c_crc_ign = s_crc_ign;
      c_len_ign = s_len_ign;
      c_idle_en = s_idle_en;
      c_pat     = s_pat;
      c_mask    = s_mask;
      c_inh     = s_inh;
      c_par_en  = s_par_en;
    end
  end

  assign byte_bad  = in_valid && c_par_en && !odd_ok(in_byte, in_par);
  assign cell_pbad = (first_b ? 1'b0 : pbad_q) | byte_bad;
  assign idle_hit  = c_idle_en && (((hdr_q ^ c_pat) & c_mask) == '0);

  assign wr_en   = in_valid;
  assign wr_data = in_byte;
  assign wr_addr = bank_q ? (ADDR_W'(CELL_BYTES) + ADDR_W'(idx_q)) : ADDR_W'(idx_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q     <= '0;
      bank_q    <= 1'b0;
      s_port    <= '0;
      s_rx_off  <= 1'b0;
      s_crc_ign <= 1'b0;
      s_len_ign <= 1'b0;
      s_idle_en <= 1'b0;
      s_pat     <= '0;
      s_mask    <= '0;
      s_inh     <= 1'b0;
      s_par_en  <= 1'b0;
      hdr_q     <= '0;
      pbad_q    <= 1'b0;
    end else if (in_valid) begin
      pbad_q <= cell_pbad;
      if (first_b) begin
        s_port    <= c_port;
        s_rx_off  <= c_rx_off;
        s_crc_ign <= c_crc_ign;
        s_len_ign <= c_len_ign;
        s_idle_en <= c_idle_en;
        s_pat     <= c_pat;
        s_mask    <= c_mask;
        s_inh     <= c_inh;
        s_par_en  <= c_par_en;
      end
      if (idx_q < HDR_END) hdr_q <= {hdr_q[HDR_W-9:0], in_byte};
      if (last_b) begin
        idx_q  <= '0;
        bank_q <= ~bank_q;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done <= 1'b0;
      desc <= '0;
    end else begin
      done <= last_b;
      if (last_b) begin
        desc.port       <= c_port;
        desc.bank       <= bank_q;
        desc.rx_off     <= c_rx_off;
        desc.idle_hit   <= idle_hit;
        desc.crc_bad    <= ~in_crc_ok;
        desc.crc_ign    <= c_crc_ign;
        desc.len_bad    <= ~in_len_ok;
        desc.len_ign    <= c_len_ign;
        desc.par_bad    <= cell_pbad;
        desc.strobe_inh <= c_inh;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      par_err_pulse <= 1'b0;
      par_err_flag  <= 1'b0;
    end else begin
      par_err_pulse <= byte_bad && par_chk_en;
      if (!par_chk_en)   par_err_flag <= 1'b0;
      else if (byte_bad) par_err_flag <= 1'b1;
    end
  end

  // R3
  soc_align_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_soc) |-> (idx_q == '0));
  // R3
  soc_present_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && idx_q == '0) |-> in_soc);
  // R10
  par_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(par_chk_en) |-> (!par_err_flag && !par_err_pulse));
endmodule

// File: rtl/cell_verdict.sv
module cell_verdict
  import cell_screen_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done,
  input  cell_desc_t        desc,
  output logic              start,
  output logic              fwd,
  output logic [PORT_W-1:0] port,
  output logic              bank,
  output logic              crc_err_pulse,
  output logic              len_err_pulse,
  output logic [CNT_W-1:0]  crc_err_cnt,
  output logic [CNT_W-1:0]  len_err_cnt
);
  logic invalid;

  always_comb begin
    invalid = (desc.crc_bad && !desc.crc_ign)
            | (desc.len_bad && !desc.len_ign)
            | desc.par_bad;
    fwd   = !desc.rx_off && !desc.idle_hit && !(desc.strobe_inh && invalid);
    start = done;
    port  = desc.port;
    bank  = desc.bank;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      crc_err_pulse <= 1'b0;
      len_err_pulse <= 1'b0;
      crc_err_cnt   <= '0;
      len_err_cnt   <= '0;
    end else begin
      crc_err_pulse <= done && desc.crc_bad;
      len_err_pulse <= done && desc.len_bad;
      if (done && desc.crc_bad) crc_err_cnt <= crc_err_cnt + 1'b1;
      if (done && desc.len_bad) len_err_cnt <= len_err_cnt + 1'b1;
    end
  end

  // R6
  crc_cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    crc_err_pulse == (crc_err_cnt == $past(crc_err_cnt) + 1'b1));
  // R6
  len_cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    len_err_pulse == (len_err_cnt == $past(len_err_cnt) + 1'b1));
endmodule

// File: rtl/cell_playback.sv
module cell_playback
  import cell_screen_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              fwd,
  input  logic [PORT_W-1:0] port,
  input  logic              bank,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  output logic [7:0]        out_byte,
  output logic [PORTS-1:0]  out_wr
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELL_BYTES - 1);

  logic              active;
  logic [IDX_W-1:0]  idx_q;
  logic              bank_q, fwd_q;
  logic [PORT_W-1:0] port_q;
  logic              dv_q;
  logic [PORT_W-1:0] dv_port;
  logic              cell_end;

  assign cell_end = active && (idx_q == LAST_IDX);
  assign rd_addr  = bank_q ? (ADDR_W'(CELL_BYTES) + ADDR_W'(idx_q)) : ADDR_W'(idx_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      idx_q  <= '0;
      bank_q <= 1'b0;
      fwd_q  <= 1'b0;
      port_q <= '0;
    end else if (start) begin
      active <= 1'b1;
      idx_q  <= '0;
      bank_q <= bank;
      fwd_q  <= fwd;
      port_q <= port;
    end else if (active) begin
      if (cell_end) active <= 1'b0;
      else          idx_q  <= idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dv_q     <= 1'b0;
      dv_port  <= '0;
      out_byte <= '0;
      out_wr   <= '0;
    end else begin
      dv_q     <= active && fwd_q;
      dv_port  <= port_q;
      out_byte <= rd_data;
      out_wr   <= dv_q ? (PORTS'(1) << dv_port) : '0;
    end
  end

  // R1
  replay_pace_chk: assert property (@(posedge clk) disable iff (rst)
    start |-> (!active || cell_end));
  // R12
  wr_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(out_wr));
  // R12
  wr_port_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_wr != '0 && $past(out_wr) != '0) |-> (out_wr == $past(out_wr)));
endmodule

// File: rtl/cell_screen_filter.sv
module cell_screen_filter
  import cell_screen_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_soc,
  input  logic [7:0]        in_byte,
  input  logic              in_par,
  input  logic [PORT_W-1:0] in_port,
  input  logic              in_crc_ok,
  input  logic              in_len_ok,
  input  logic [PORTS-1:0]  port_rx_off,
  input  logic [PORTS-1:0]  port_crc_ign,
  input  logic [PORTS-1:0]  port_len_ign,
  input  logic              idle_drop_en,
  input  logic [HDR_W-1:0]  idle_pattern,
  input  logic [HDR_W-1:0]  idle_mask,
  input  logic              invalid_strobe_inh,
  input  logic              par_chk_en,
  output logic [7:0]        out_byte,
  output logic [PORTS-1:0]  out_wr,
  output logic              crc_err_pulse,
  output logic              len_err_pulse,
  output logic              par_err_pulse,
  output logic              par_err_flag,
  output logic [CNT_W-1:0]  crc_err_cnt,
  output logic [CNT_W-1:0]  len_err_cnt
);
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [7:0]        wr_data, rd_data;
  logic              done, start, fwd, bank;
  cell_desc_t        desc;
  logic [PORT_W-1:0] port;

  cell_capture u_capture (
    .clk, .rst, .in_valid, .in_soc, .in_byte, .in_par, .in_port,
    .in_crc_ok, .in_len_ok, .port_rx_off, .port_crc_ign, .port_len_ign,
    .idle_drop_en, .idle_pattern, .idle_mask, .invalid_strobe_inh, .par_chk_en,
    .wr_en, .wr_addr, .wr_data, .done, .desc, .par_err_pulse, .par_err_flag
  );

  cell_buffer #(.DW(8), .DEPTH(BUF_DEPTH), .AW(ADDR_W)) u_buffer (
    .clk, .wr_en, .wr_addr, .wr_data, .rd_addr, .rd_data
  );

  cell_verdict #(.CNT_W(CNT_W)) u_verdict (
    .clk, .rst, .done, .desc, .start, .fwd, .port, .bank,
    .crc_err_pulse, .len_err_pulse, .crc_err_cnt, .len_err_cnt
  );

  cell_playback u_playback (
    .clk, .rst, .start, .fwd, .port, .bank, .rd_addr, .rd_data,
    .out_byte, .out_wr
  );
endmodule

// File: tb/cell_screen_filter_test.sv
module cell_screen_filter_test;
  localparam int NB = 53;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, in_soc = 1'b0, in_par = 1'b0;
  logic [7:0]  in_byte = '0;
  logic [1:0]  in_port = '0;
  logic        in_crc_ok = 1'b1, in_len_ok = 1'b1;
  logic [3:0]  port_rx_off = '0, port_crc_ign = '0, port_len_ign = '0;
  logic        idle_drop_en = 1'b0, invalid_strobe_inh = 1'b0, par_chk_en = 1'b0;
  logic [31:0] idle_pattern = '0, idle_mask = '0;
  logic [7:0]  out_byte;
  logic [3:0]  out_wr;
  logic        crc_err_pulse, len_err_pulse, par_err_pulse, par_err_flag;
  logic [15:0] crc_err_cnt, len_err_cnt;

  cell_screen_filter uut (.*);

  always #10ns clk = ~clk;

  int checks = 0, fails = 0;
  int wcnt [4];
  logic [7:0] cap [4][64];
  logic [7:0] exp_b [NB];
  int crc_p = 0, len_p = 0, par_p = 0, multi = 0;
  int exp_crc = 0, exp_len = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if ($countones(out_wr) > 1) multi++;
      for (int p = 0; p < 4; p++)
        if (out_wr[p]) begin
          if (wcnt[p] < 64) cap[p][wcnt[p]] = out_byte;
          wcnt[p]++;
        end
      if (crc_err_pulse) crc_p++;
      if (len_err_pulse) len_p++;
      if (par_err_pulse) par_p++;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  function automatic bit exp_fwd(int p, logic [31:0] h, bit cok, bit lok, bit pbad);
    bit inval, idle;
    inval = (!cok && !port_crc_ign[p]) || (!lok && !port_len_ign[p]) || (pbad && par_chk_en);
    idle  = idle_drop_en && (((h ^ idle_pattern) & idle_mask) == 32'h0);
    return !port_rx_off[p] && !idle && !(invalid_strobe_inh && inval);
  endfunction

  task automatic send_cell(input int port, input logic [31:0] h, input int seed,
                           input bit cok, input bit lok, input int bad_par, input int flip);
    for (int k = 0; k < NB; k++) begin
      logic [7:0] b;
      b = (k < 4) ? h[31-8*k -: 8] : 8'((seed * 13 + k * 7) & 255);
      exp_b[k] = b;
      @(negedge clk);
      in_valid  = 1'b1;
      in_soc    = (k == 0);
      in_port   = 2'(port);
      in_byte   = b;
      in_par    = (~^b) ^ (k == bad_par);
      in_crc_ok = cok;
      in_len_ok = lok;
      if (k == flip) port_rx_off[port] = ~port_rx_off[port];
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_soc   = 1'b0;
    if (!cok) exp_crc++;
    if (!lok) exp_len++;
    repeat (60) @(negedge clk);
  endtask

  task automatic verify(input int port, input bit fwd, input string tag);
    for (int p = 0; p < 4; p++) begin
      int n, mism;
      n = (fwd && p == port) ? NB : 0;
      chk(wcnt[p] == n, tag, wcnt[p], n);
      mism = 0;
      if (n != 0)
        for (int k = 0; k < NB; k++) if (cap[p][k] !== exp_b[k]) mism++;
      if (n != 0) chk(mism == 0, {tag, " R1 data"}, mism, 0);
      wcnt[p] = 0;
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    bit f;
    for (int p = 0; p < 4; p++) wcnt[p] = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(out_wr == 0, "R11 out_wr", out_wr, 0);
    chk(crc_err_cnt == 0 && len_err_cnt == 0, "R11 counters", crc_err_cnt, 0);
    chk(!par_err_flag && !par_err_pulse && !crc_err_pulse && !len_err_pulse, "R11 flags", par_err_flag, 0);

    // R1 R2: sweep all reception-disable patterns over all ports
    for (int d = 0; d < 16; d++)
      for (int p = 0; p < 4; p++) begin
        port_rx_off = 4'(d);
        f = exp_fwd(p, 32'h0102_0300 + 32'(d), 1, 1, 0);
        send_cell(p, 32'h0102_0300 + 32'(d), d * 4 + p, 1, 1, -1, -1);
        verify(p, f, "R2 R1 rx disable sweep");
      end
    port_rx_off = '0;

    // R3: toggling reception disable mid-cell
    send_cell(1, 32'h1111_2222, 7, 1, 1, -1, 20);
    verify(1, 1, "R3 off mid-cell");
    send_cell(1, 32'h1111_2222, 9, 1, 1, -1, 20);
    verify(1, 0, "R3 on mid-cell");
    port_rx_off = '0;

    // R4 R5 R6 R8: check-ignore, inhibit and counter sweep
    for (int p = 0; p < 4; p++)
      for (int m = 0; m < 32; m++) begin
        bit cok, lok;
        int c0, l0;
        cok = m[0]; lok = m[1];
        port_crc_ign = m[2] ? 4'(1 << p) : 4'h0;
        port_len_ign = m[3] ? 4'(1 << p) : 4'h0;
        invalid_strobe_inh = m[4];
        f = exp_fwd(p, 32'h0A0B_0C0D, cok, lok, 0);
        c0 = crc_p; l0 = len_p;
        send_cell(p, 32'h0A0B_0C0D, m + 40, cok, lok, -1, -1);
        verify(p, f, "R4 R5 R8 check sweep");
        chk(crc_err_cnt == 16'(exp_crc), "R6 crc count", crc_err_cnt, exp_crc);
        chk(len_err_cnt == 16'(exp_len), "R6 len count", len_err_cnt, exp_len);
        chk(crc_p - c0 == int'(!cok), "R6 crc pulse", crc_p - c0, int'(!cok));
        chk(len_p - l0 == int'(!lok), "R6 len pulse", len_p - l0, int'(!lok));
      end
    port_crc_ign = '0; port_len_ign = '0; invalid_strobe_inh = 1'b0;

    // R7: idle deletion with mask
    idle_pattern = 32'h0000_0001;
    idle_mask    = 32'hFFFF_FF0F;
    for (int e = 0; e < 2; e++) begin
      logic [31:0] hs [3];
      idle_drop_en = e[0];
      hs[0] = 32'h0000_0001; hs[1] = 32'h0000_00F1; hs[2] = 32'h0000_0003;
      for (int i = 0; i < 3; i++) begin
        f = exp_fwd(2, hs[i], 1, 1, 0);
        send_cell(2, hs[i], 60 + i, 1, 1, -1, -1);
        verify(2, f, "R7 idle match");
      end
    end
    idle_mask = '0; idle_drop_en = 1'b1;
    send_cell(3, 32'hDEAD_BEEF, 5, 1, 1, -1, -1);
    verify(3, 0, "R7 empty mask");
    idle_drop_en = 1'b0;

    // R9: parity checking enabled
    par_chk_en = 1'b1;
    invalid_strobe_inh = 1'b1;
    par_p = 0;
    send_cell(0, 32'h0505_0505, 3, 1, 1, 10, -1);
    verify(0, 0, "R9 parity drop");
    chk(par_p == 1, "R9 pulse", par_p, 1);
    chk(par_err_flag == 1'b1, "R9 sticky", par_err_flag, 1);
    invalid_strobe_inh = 1'b0;
    send_cell(0, 32'h0505_0505, 4, 1, 1, 0, -1);
    verify(0, 1, "R9 R8 parity forward");
    chk(par_p == 2, "R9 pulse 2", par_p, 2);

    // R10: parity checking disabled
    par_chk_en = 1'b0;
    invalid_strobe_inh = 1'b1;
    @(negedge clk);
    chk(par_err_flag == 1'b0, "R10 flag cleared", par_err_flag, 0);
    send_cell(1, 32'h0606_0606, 8, 1, 1, 30, -1);
    verify(1, 1, "R10 parity ignored");
    chk(par_p == 2, "R10 no pulse", par_p, 2);
    chk(par_err_flag == 1'b0, "R10 flag low", par_err_flag, 0);

    // R12
    chk(multi == 0, "R12 one-hot strobes", multi, 0);
    finish_run();
  end
endmodule